// File: doc/BRIEF.md
# Dual-Mode Serial Result Port

This block is the output stage of a converter. It takes a signed raw result from the filter, clamps it into a 20-bit output code and holds that code for a host to read one bit at a time. A low-active data-ready flag tells the host that a fresh word is waiting. A low-active select input opens a transfer. Data leaves most significant bit first on a serial data line whose driver is switched off between words.

Two shifting modes exist, chosen when each transfer starts. In the self-clocked mode the port makes its own serial clock from the master clock, with a fixed low phase and high phase per bit. In the host-clocked mode the host drives the serial clock and the port moves to the next bit on each falling edge. In both modes, raising select in the middle of a word finishes the current bit and then releases the line. For a few master cycles after a new word is presented, select is not recognised. A result that arrives during a transfer waits in a staging register until the transfer is over.

Top module: `result_serial_port`

## Requirements
- R1: In self-clocked mode a word is 20 bits sent most significant first. The driven serial clock is low for 3 master cycles and then high for 1 master cycle per bit. Data holds steady through each rising edge.
- R2: In self-clocked mode the data enable and the clock enable drop one master cycle after the final rising edge. Both enables stay low whenever no transfer is running.
- R3: In host-clocked mode the port never enables its clock output. It presents bit 19 when the transfer starts. It moves to the next bit only after a host falling edge. The data enable drops after the falling edge that follows bit 0.
- R4: If select goes high during a word, the port completes the current bit and then releases the line. The word stays unread with data-ready still low, and the next transfer sends it again from bit 19.
- R5: After a word is committed (data-ready falls), a held-low select starts a transfer no earlier than 5 master cycles later. The data enable rises exactly in the 5th cycle.
- R6: Data-ready falls two master cycles after a load strobe when no word is pending. It rises when the final bit of a full transfer has completed.
- R7: A load that arrives while an unread word waits and no transfer is running replaces that word. Data-ready is high for exactly one master cycle between the two words.
- R8: A load during a transfer does not change the word being sent. The new word is committed after the transfer ends and is sent by the next transfer.
- R9: In unipolar mode (bipolar input low) a negative raw value gives code 0x00000. A raw value above 0xFFFFF gives 0xFFFFF. Any other value is sent unchanged.
- R10: In bipolar mode the code is the raw value plus 0x80000 (offset binary), so 0 gives 0x80000 and -1 gives 0x7FFFF. Sums below 0 clamp to 0x00000 and sums above 0xFFFFF clamp to 0xFFFFF.
- R11: During and right after reset, data-ready is high and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_ext | input | 1 | 1 = host supplies serial clock, 0 = port drives it; sampled at transfer start |
| bipolar | input | 1 | 1 = offset-binary coding of the raw value; sampled with the load strobe |
| res_in | input | 22 | Signed raw result from the filter |
| res_load | input | 1 | One-cycle strobe that captures res_in |
| cs_n | input | 1 | Active-low select from the host, asynchronous |
| sclk_in | input | 1 | Host serial clock, used in host-clocked mode |
| sclk_out | output | 1 | Serial clock driven in self-clocked mode |
| sclk_oe | output | 1 | Drive enable for sclk_out |
| sdata | output | 1 | Serial data, most significant bit first |
| sdata_oe | output | 1 | Drive enable for sdata |
| drdy_n | output | 1 | Active-low data-ready flag |

## Verification
A bit counter or phase counter that has slipped shows up within a single word. The host reads a shifted or truncated value, or the clock high phase lasts longer than one cycle, and the enable drops before or after the last rising edge. A fault in the valid and staging state shows up on data-ready within two or three master cycles of a load. Data-ready may not fall, may skip the one-cycle gap on an overwrite, or may stay low after a complete read. A blanking counter that ends early or late moves the first enable rise away from its fixed 5-cycle slot after data-ready falls.

// File: rtl/sop_pkg.sv
package sop_pkg;
    localparam int DEF_WORD_W    = 20;
    localparam int DEF_RAW_W     = 22;
    localparam int DEF_BLANK_CYC = 4;
    localparam int DEF_SCLK_LOW  = 3;
    localparam int DEF_SCLK_HIGH = 1;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } sh_state_t;
endpackage

// File: rtl/sop_sync.sv
module sop_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sop_clamp.sv
module sop_clamp #(
    parameter int RAW_W  = sop_pkg::DEF_RAW_W,
    parameter int WORD_W = sop_pkg::DEF_WORD_W
) (
    input  logic [RAW_W-1:0]  raw,
    input  logic              bipolar,
    output logic [WORD_W-1:0] code
);
    localparam int XW = RAW_W + 1;
    localparam logic signed [XW-1:0] HALF = XW'(1) << (WORD_W - 1);
    localparam logic signed [XW-1:0] TOP  = (XW'(1) << WORD_W) - XW'(1);

    logic signed [XW-1:0] ext;
    logic signed [XW-1:0] shifted;

    always_comb begin
        ext     = {raw[RAW_W-1], raw};
        shifted = bipolar ? ext + HALF : ext;
        if (shifted < 0)        code = '0;
        else if (shifted > TOP) code = '1;
        else                    code = shifted[WORD_W-1:0];
    end
endmodule

// File: rtl/sop_stage.sv
module sop_stage #(
    parameter int RAW_W     = sop_pkg::DEF_RAW_W,
    parameter int WORD_W    = sop_pkg::DEF_WORD_W,
    parameter int BLANK_CYC = sop_pkg::DEF_BLANK_CYC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [RAW_W-1:0]  raw,
    input  logic              bipolar,
    input  logic              busy,
    input  logic              done_full,
    output logic [WORD_W-1:0] word,
    output logic              valid,
    output logic              pend,
    output logic              blank_clr
);
    localparam int BLK_W = $clog2(BLANK_CYC + 1);

    logic [WORD_W-1:0] clamped;
    logic [WORD_W-1:0] stage_q;
    logic [WORD_W-1:0] word_q;
    logic              valid_q;
    logic              pend_q;
    logic [BLK_W-1:0]  blank_cnt;

    sop_clamp #(.RAW_W(RAW_W), .WORD_W(WORD_W)) u_clamp (
        .raw     (raw),
        .bipolar (bipolar),
        .code    (clamped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q   <= '0;
            word_q    <= '0;
            valid_q   <= 1'b0;
            pend_q    <= 1'b0;
            blank_cnt <= '0;
        end else begin
            if (blank_cnt != '0) blank_cnt <= blank_cnt - 1'b1;
            if (done_full) begin
                valid_q <= 1'b0;
            end else if (!busy && pend_q) begin
                if (valid_q) begin
                    valid_q <= 1'b0;
                end else begin
                    word_q    <= stage_q;
                    valid_q   <= 1'b1;
                    pend_q    <= 1'b0;
                    blank_cnt <= BLK_W'(BLANK_CYC);
                end
            end
            if (load) begin
                stage_q <= clamped;
                pend_q  <= 1'b1;
            end
        end
    end

    assign word      = word_q;
    assign valid     = valid_q;
    assign pend      = pend_q;
    assign blank_clr = (blank_cnt == '0);

    // R8: the word being shifted is never replaced mid-transfer
    a_r8_word_held_in_transfer: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(word_q));
endmodule

// File: rtl/sop_shifter.sv
module sop_shifter #(
    parameter int WORD_W    = sop_pkg::DEF_WORD_W,
    parameter int SCLK_LOW  = sop_pkg::DEF_SCLK_LOW,
    parameter int SCLK_HIGH = sop_pkg::DEF_SCLK_HIGH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_ext,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic [WORD_W-1:0] word,
    input  logic              valid,
    input  logic              pend,
    input  logic              blank_clr,
    output logic              busy,
    output logic              done_full,
    output logic              sdata,
    output logic              sdata_oe,
    output logic              sclk_out,
    output logic              sclk_oe
);
    import sop_pkg::*;

    localparam int PH_N    = SCLK_LOW + SCLK_HIGH;
    localparam int PH_W    = (PH_N > 1) ? $clog2(PH_N) : 1;
    localparam int PH_LAST = PH_N - 1;
    localparam int IDX_W   = $clog2(WORD_W);

    sh_state_t         st;
    logic              mode_q;
    logic [IDX_W-1:0]  idx;
    logic [PH_W-1:0]   ph;
    logic              abort_q;
    logic [WORD_W-1:0] sreg;
    logic              sk_d;
    logic              host_fall;
    logic              bit_end;
    logic              stop_req;
    logic              start;

    assign host_fall = sk_d & ~sclk_s;
    assign start     = (st == ST_IDLE) & valid & ~pend & ~cs_n_s & blank_clr;
    assign bit_end   = (st == ST_SHIFT) &
                       (mode_q ? host_fall : (ph == PH_W'(PH_LAST)));
    assign stop_req  = cs_n_s | abort_q;
    assign done_full = bit_end & (idx == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            mode_q  <= 1'b0;
            idx     <= '0;
            ph      <= '0;
            abort_q <= 1'b0;
            sreg    <= '0;
            sk_d    <= 1'b0;
        end else begin
            sk_d <= sclk_s;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        st      <= ST_SHIFT;
                        mode_q  <= mode_ext;
                        sreg    <= word;
                        idx     <= IDX_W'(WORD_W - 1);
                        ph      <= '0;
                        abort_q <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (!mode_q)
                        ph <= (ph == PH_W'(PH_LAST)) ? '0 : ph + 1'b1;
                    if (cs_n_s) abort_q <= 1'b1;
                    if (bit_end) begin
                        if (idx == '0 || stop_req) begin
                            st <= ST_IDLE;
                        end else begin
                            idx  <= idx - 1'b1;
                            sreg <= {sreg[WORD_W-2:0], 1'b0};
                        end
                    end
                end
            endcase
        end
    end

    assign busy     = (st == ST_SHIFT);
    assign sdata    = sreg[WORD_W-1];
    assign sdata_oe = busy;
    assign sclk_oe  = busy & ~mode_q;
    assign sclk_out = busy & ~mode_q & (ph >= PH_W'(SCLK_LOW));

    // R1: the driven clock high phase lasts one master cycle
    a_r1_sclk_high_single: assert property (@(posedge clk) disable iff (rst)
        sclk_out |=> !sclk_out);

    // R2: in self-clocked mode the line is released right after a high phase
    a_r2_release_after_high: assert property (@(posedge clk) disable iff (rst)
        ($fell(sdata_oe) && !mode_q) |-> $past(sclk_out));

    // R3: in host-clocked mode the port never drives the clock
    a_r3_no_clock_drive_ext: assert property (@(posedge clk) disable iff (rst)
        (busy && mode_q) |-> !sclk_oe);
endmodule

// File: rtl/result_serial_port.sv
module result_serial_port #(
    parameter int RAW_W     = sop_pkg::DEF_RAW_W,
    parameter int WORD_W    = sop_pkg::DEF_WORD_W,
    parameter int BLANK_CYC = sop_pkg::DEF_BLANK_CYC,
    parameter int SCLK_LOW  = sop_pkg::DEF_SCLK_LOW,
    parameter int SCLK_HIGH = sop_pkg::DEF_SCLK_HIGH,
    parameter int SYNC_LEN  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_ext,
    input  logic             bipolar,
    input  logic [RAW_W-1:0] res_in,
    input  logic             res_load,
    input  logic             cs_n,
    input  logic             sclk_in,
    output logic             sclk_out,
    output logic             sclk_oe,
    output logic             sdata,
    output logic             sdata_oe,
    output logic             drdy_n
);
    logic              cs_n_s;
    logic              sclk_s;
    logic [WORD_W-1:0] word;
    logic              valid;
    logic              pend;
    logic              blank_clr;
    logic              busy;
    logic              done_full;

    sop_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_cs_sync (
        .clk (clk), .rst (rst), .d (cs_n), .q (cs_n_s)
    );

    sop_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_sclk_sync (
        .clk (clk), .rst (rst), .d (sclk_in), .q (sclk_s)
    );

    sop_stage #(.RAW_W(RAW_W), .WORD_W(WORD_W), .BLANK_CYC(BLANK_CYC)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .load      (res_load),
        .raw       (res_in),
        .bipolar   (bipolar),
        .busy      (busy),
        .done_full (done_full),
        .word      (word),
        .valid     (valid),
        .pend      (pend),
        .blank_clr (blank_clr)
    );

    sop_shifter #(.WORD_W(WORD_W), .SCLK_LOW(SCLK_LOW), .SCLK_HIGH(SCLK_HIGH)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .mode_ext  (mode_ext),
        .cs_n_s    (cs_n_s),
        .sclk_s    (sclk_s),
        .word      (word),
        .valid     (valid),
        .pend      (pend),
        .blank_clr (blank_clr),
        .busy      (busy),
        .done_full (done_full),
        .sdata     (sdata),
        .sdata_oe  (sdata_oe),
        .sclk_out  (sclk_out),
        .sclk_oe   (sclk_oe)
    );

    assign drdy_n = ~valid;

    // R5: a transfer only opens once the blanking window has run out
    a_r5_start_after_blank: assert property (@(posedge clk) disable iff (rst)
        $rose(sdata_oe) |-> $past(blank_clr));

    // R6: data-ready stays low for the whole of a transfer
    a_r6_drdy_low_in_shift: assert property (@(posedge clk) disable iff (rst)
        sdata_oe |-> !drdy_n);
endmodule

// File: tb/test_result_serial_port.sv
`timescale 1ns/1ps
module test_result_serial_port;
    localparam int RAW_W = 22;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mode_ext = 1'b0;
    logic             bipolar = 1'b0;
    logic [RAW_W-1:0] res_in = '0;
    logic             res_load = 1'b0;
    logic             cs_n = 1'b1;
    logic             sclk_in = 1'b0;
    logic             sclk_out, sclk_oe, sdata, sdata_oe, drdy_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    result_serial_port i_result_serial_port (
        .clk (clk), .rst (rst), .mode_ext (mode_ext), .bipolar (bipolar),
        .res_in (res_in), .res_load (res_load), .cs_n (cs_n), .sclk_in (sclk_in),
        .sclk_out (sclk_out), .sclk_oe (sclk_oe), .sdata (sdata),
        .sdata_oe (sdata_oe), .drdy_n (drdy_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] model(input logic signed [RAW_W-1:0] raw, input bit bip);
        int v;
        v = raw;
        if (bip) v = v + 524288;
        if (v < 0) return 20'h00000;
        if (v > 1048575) return 20'hFFFFF;
        return v[19:0];
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load_word(input logic [RAW_W-1:0] raw, input bit bip);
        res_in = raw; bipolar = bip; res_load = 1'b1;
        tick();
        res_load = 1'b0;
    endtask

    task automatic wait_drdy(input string req);
        int n = 0;
        while (drdy_n && n < 20) begin tick(); n++; end
        check(!drdy_n, req, "data-ready low", 32'(drdy_n), 0);
    endtask

    task automatic wait_oe(output bit ok);
        int n = 0;
        while (!sdata_oe && n < 40) begin tick(); n++; end
        ok = sdata_oe;
    endtask

    // self-clocked receive; optionally loads a new raw value mid-word (R8)
    task automatic recv_self(input logic [19:0] exp, input string req,
                             input bit mid_load, input logic [RAW_W-1:0] mid_raw);
        bit ok, prev, bad_phase, loaded;
        int bits, lowrun, highrun, cyc;
        logic [19:0] got;
        prev = 0; bad_phase = 0; loaded = 0;
        bits = 0; lowrun = 0; highrun = 0; cyc = 0; got = '0;
        wait_oe(ok);
        check(ok, req, "transfer started", 32'(ok), 1);
        while (sdata_oe && cyc < 400) begin
            if (!sclk_oe) bad_phase = 1;
            if (sclk_out) begin
                if (!prev) begin
                    got = {got[18:0], sdata};
                    bits++;
                    if (lowrun != 3) bad_phase = 1;
                    lowrun = 0;
                end
                highrun++;
            end else begin
                if (prev) begin
                    if (highrun != 1) bad_phase = 1;
                    highrun = 0;
                end
                lowrun++;
            end
            prev = sclk_out;
            if (mid_load && bits == 10 && !loaded) begin
                res_in = mid_raw; bipolar = 1'b0; res_load = 1'b1; loaded = 1;
            end
            tick();
            res_load = 1'b0;
            cyc++;
        end
        check(bits == 20, req, "bit count", 32'(bits), 20);
        check(got == exp, req, "received word", 32'(got), 32'(exp));
        check(!bad_phase && highrun == 1, "R1", "clock phases 3 low / 1 high", 32'(bad_phase), 0);
        check(prev && !sclk_oe, "R2", "release one cycle after last rise", 32'({prev, sclk_oe}), 32'h2);
    endtask

    task automatic recv_ext(input logic [19:0] exp, input string req);
        bit ok, bad_hold, drove;
        logic [19:0] got;
        logic b;
        bad_hold = 0; drove = 0; got = '0;
        wait_oe(ok);
        check(ok, req, "transfer started", 32'(ok), 1);
        for (int i = 0; i < 20; i++) begin
            b = sdata;
            if (sclk_oe) drove = 1;
            sclk_in = 1'b1;
            repeat (8) tick();
            if (sdata !== b || !sdata_oe) bad_hold = 1;
            if (sclk_oe) drove = 1;
            got = {got[18:0], b};
            sclk_in = 1'b0;
            repeat (8) tick();
        end
        check(got == exp, req, "host-clocked word", 32'(got), 32'(exp));
        check(!bad_hold, req, "data stable through high phase", 32'(bad_hold), 0);
        check(!drove, req, "clock output never enabled", 32'(drove), 0);
        check(!sdata_oe, req, "released after final falling edge", 32'(sdata_oe), 0);
    endtask

    task automatic t_reset();
        check(drdy_n && !sdata_oe && !sclk_oe, "R11", "reset outputs",
              32'({drdy_n, sdata_oe, sclk_oe}), 32'h4);
    endtask

    task automatic t_basic();
        logic [19:0] e;
        e = model(22'h05A3C1, 0);
        load_word(22'h05A3C1, 0);
        check(drdy_n, "R6", "data-ready still high one cycle after load", 32'(drdy_n), 1);
        tick();
        check(!drdy_n, "R6", "data-ready low two cycles after load", 32'(drdy_n), 0);
        check(!sdata_oe && !sclk_oe, "R2", "idle enables low", 32'({sdata_oe, sclk_oe}), 0);
        cs_n = 1'b0;
        recv_self(e, "R1", 0, '0);
        check(drdy_n, "R6", "data-ready high after full read", 32'(drdy_n), 1);
        cs_n = 1'b1;
        repeat (4) tick();
    endtask

    task automatic t_code(input logic [RAW_W-1:0] raw, input bit bip, input string req);
        load_word(raw, bip);
        wait_drdy(req);
        cs_n = 1'b0;
        recv_self(model(raw, bip), req, 0, '0);
        cs_n = 1'b1;
        repeat (4) tick();
    endtask

    task automatic t_ext();
        logic [19:0] e;
        e = model(22'h0C35A9, 0);
        mode_ext = 1'b1;
        load_word(22'h0C35A9, 0);
        wait_drdy("R3");
        cs_n = 1'b0;
        recv_ext(e, "R3");
        check(drdy_n, "R6", "data-ready high after host read", 32'(drdy_n), 1);
        cs_n = 1'b1;
        mode_ext = 1'b0;
        repeat (4) tick();
    endtask

    task automatic t_abort();
        bit ok, prev, raised;
        int bits, cyc;
        logic [19:0] got, e;
        e = model(22'h0B6D5B, 0);
        prev = 0; raised = 0; bits = 0; cyc = 0; got = '0;
        load_word(22'h0B6D5B, 0);
        wait_drdy("R4");
        cs_n = 1'b0;
        wait_oe(ok);
        while (sdata_oe && cyc < 400) begin
            if (sclk_out && !prev) begin
                got = {got[18:0], sdata};
                bits++;
                if (bits == 6 && !raised) begin cs_n = 1'b1; raised = 1; end
            end
            prev = sclk_out;
            tick();
            cyc++;
        end
        check(bits >= 6 && bits < 20, "R4", "early end bit count", 32'(bits), 7);
        check(prev, "R4", "current bit completed before release", 32'(prev), 1);
        check(got == (e >> (20 - bits)), "R4", "partial word prefix", 32'(got), 32'(e >> (20 - bits)));
        check(!drdy_n, "R4", "word still unread after early end", 32'(drdy_n), 0);
        repeat (6) tick();
        cs_n = 1'b0;
        recv_self(e, "R4", 0, '0);
        cs_n = 1'b1;
        repeat (4) tick();
    endtask

    task automatic t_blank();
        int n;
        bit early;
        cs_n = 1'b0;
        repeat (6) tick();
        load_word(22'h012345, 0);
        wait_drdy("R5");
        n = 0; early = 0;
        while (!sdata_oe && n < 12) begin
            tick(); n++;
        end
        check(n == 5, "R5", "cycles from data-ready to transfer start", 32'(n), 5);
        recv_self(model(22'h012345, 0), "R5", 0, '0);
        cs_n = 1'b1;
        repeat (4) tick();
    endtask

    task automatic t_overwrite();
        int highs;
        load_word(22'h0AAAAA, 0);
        wait_drdy("R7");
        repeat (6) tick();
        load_word(22'h055555, 0);
        highs = 0;
        for (int i = 0; i < 8; i++) begin
            if (drdy_n) highs++;
            tick();
        end
        check(highs == 1, "R7", "data-ready high cycles on overwrite", 32'(highs), 1);
        check(!drdy_n, "R7", "new word ready", 32'(drdy_n), 0);
        cs_n = 1'b0;
        recv_self(20'h55555, "R7", 0, '0);
        cs_n = 1'b1;
        repeat (4) tick();
    endtask

    task automatic t_staging();
        load_word(22'h0F0F0F, 0);
        wait_drdy("R8");
        cs_n = 1'b0;
        recv_self(20'hF0F0F, "R8", 1, 22'h03C3C3);
        recv_self(20'h3C3C3, "R8", 0, '0);
        check(drdy_n, "R8", "staged word consumed", 32'(drdy_n), 1);
        cs_n = 1'b1;
        repeat (4) tick();
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst = 1'b0;
        tick();
        t_reset();
        t_basic();
        t_code(22'h3FFFF0, 0, "R9");   // negative
        t_code(22'h100005, 0, "R9");   // above full scale
        t_code(22'h0FFFFF, 0, "R9");   // exactly full scale
        t_code(22'h000000, 1, "R10");  // midscale
        t_code(22'h3FFFFF, 1, "R10");  // -1
        t_code(22'h380000, 1, "R10");  // lowest in range
        t_code(22'h37FFFF, 1, "R10");  // below range
        t_code(22'h080000, 1, "R10");  // above range
        t_code(22'h07FFFF, 1, "R10");  // highest in range
        t_ext();
        t_abort();
        t_blank();
        t_overwrite();
        t_staging();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule